// File: doc/BRIEF.md
# Single-to-Double Widening and Sign Operations Unit

This unit takes one 32-bit single-precision operand, an optional second operand and a 2-bit operation code. It performs one of four operations. Widening produces the exact double-precision value of the operand. Absolute value, negation and copy-sign work on the single-precision bit pattern and return it zero-extended to 64 bits. Each result comes with a five-bit exception flag vector. Widening is a computational operation, so a signaling NaN is quieted and reported as invalid. The three sign operations only edit the sign bit and never report anything.

The input side uses a valid/ready handshake and accepts a new operand on every cycle once reset is released. Each accepted operation produces a one-cycle `out_valid` strobe exactly two clock edges after acceptance. The pipeline is two registers deep: decode and classification in the first stage, result assembly in the second.

Top module: `fp_widen_sign_unit`

## Requirements
- R1: Operation codes: 0 widen, 1 absolute value, 2 negate, 3 copy-sign. Widening a normal operand gives sign kept, exponent `e + 896` (rebias 1023 − 127) and fraction `{f, 29'b0}`, with no flags.
- R2: Widening a subnormal operand (exponent 0, fraction f ≠ 0) gives the exact normal double. With k = leading zeros of the 23-bit f, the exponent is `896 − k` and the fraction bits below the leading one are left-aligned, with no flags.
- R3: Widening a zero or an infinity keeps its sign and gives a double zero or a double infinity, with no flags.
- R4: A NaN is signaling when fraction bit 22 is 0. Widening a signaling NaN gives exponent all ones, the payload `{f, 29'b0}` with the quiet bit (result bit 51) set, and the invalid flag. For example 0x7fa00000 becomes 0x7ffc000000000000.
- R5: Widening a quiet NaN keeps its sign and payload (`{f, 29'b0}`) and raises no flag.
- R6: Absolute value returns `{32'b0, 1'b0, a[30:0]}` and raises no flag, even for a signaling NaN.
- R7: Negate returns `{32'b0, ~a[31], a[30:0]}` and raises no flag, even for a signaling NaN.
- R8: Copy-sign returns `{32'b0, b[31], a[30:0]}` and raises no flag.
- R9: `out_valid` is high in the cycle after the second rising edge following an accepted transfer and is low otherwise. Back-to-back transfers give back-to-back results.
- R10: During reset `in_ready` and `out_valid` are low. After reset `in_ready` is high.
- R11: The flag vector is {invalid, divide-by-zero, overflow, underflow, inexact}, with invalid at bit 4. Bits 3..0 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation presented |
| in_ready | output | 1 | Unit accepts an operation this cycle |
| in_op | input | 2 | Operation code (R1) |
| in_a | input | 32 | Single-precision operand |
| in_b | input | 32 | Sign source for copy-sign |
| out_valid | output | 1 | Result strobe |
| out_result | output | 64 | Double result or zero-extended single result |
| out_flags | output | 5 | Exception flags {invalid, div0, overflow, underflow, inexact} |

## Verification
Directed operands cover each widening class: normal values, the largest and smallest subnormals, both signed zeros and infinities, and quiet and signaling NaNs with distinct payloads. These cases separate the rebias, normalize, pass-through and quieting paths. The same signaling NaNs go through absolute value, negate and copy-sign, which shows that only widening raises invalid. Random operands are biased toward exponent 0 and exponent 255 and sent with random operation codes and idle gaps. This tests the classification edges and the two-cycle strobe timing under back-to-back and sparse traffic.

// File: rtl/fpws_pkg.sv
package fpws_pkg;
    localparam int SP_W      = 32;
    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int DP_W      = 64;
    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;
    localparam int SP_BIAS   = 127;
    localparam int DP_BIAS   = 1023;
    localparam int REBIAS    = DP_BIAS - SP_BIAS;
    localparam int PAD_W     = DP_FRAC_W - SP_FRAC_W;
    localparam int LZ_W      = $clog2(SP_FRAC_W + 1);
    localparam int FLAG_W    = 5;

    typedef enum logic [1:0] {
        OP_WIDEN = 2'd0,
        OP_ABS   = 2'd1,
        OP_NEG   = 2'd2,
        OP_CPSGN = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUB,
        CLS_NORM,
        CLS_INF,
        CLS_QNAN,
        CLS_SNAN
    } cls_e;

    typedef struct packed {
        logic invalid;
        logic div_zero;
        logic overflow;
        logic underflow;
        logic inexact;
    } flags_t;

    typedef struct packed {
        op_e                  op;
        logic                 sign;
        logic                 sign_b;
        logic [SP_EXP_W-1:0]  exp;
        logic [SP_FRAC_W-1:0] frac;
        cls_e                 cls;
        logic [LZ_W-1:0]      lz;
    } stage1_t;

    typedef struct packed {
        logic [DP_W-1:0] result;
        flags_t          flags;
    } stage2_t;

    function automatic cls_e classify(input logic [SP_EXP_W-1:0] e,
                                      input logic [SP_FRAC_W-1:0] f);
        cls_e c;
        if (e == '0)
            c = (f == '0) ? CLS_ZERO : CLS_SUB;
        else if (e == '1)
            c = (f == '0) ? CLS_INF : (f[SP_FRAC_W-1] ? CLS_QNAN : CLS_SNAN);
        else
            c = CLS_NORM;
        return c;
    endfunction
endpackage

// File: rtl/fpws_lzc.sv
module fpws_lzc #(
    parameter int W  = 23,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);
    always_comb begin
        logic found;
        found = 1'b0;
        count = CW'(W);
        for (int i = W - 1; i >= 0; i--) begin
            if (!found && vec[i]) begin
                found = 1'b1;
                count = CW'(W - 1 - i);
            end
        end
    end
endmodule

// File: rtl/fpws_decode.sv
module fpws_decode
    import fpws_pkg::*;
(
    input  logic [1:0]      op,
    input  logic [SP_W-1:0] a,
    input  logic [SP_W-1:0] b,
    output stage1_t         dec
);
    logic [LZ_W-1:0] lz;

    fpws_lzc #(.W(SP_FRAC_W), .CW(LZ_W)) u_lzc (
        .vec   (a[SP_FRAC_W-1:0]),
        .count (lz)
    );

    always_comb begin
        dec.op     = op_e'(op);
        dec.sign   = a[SP_W-1];
        dec.sign_b = b[SP_W-1];
        dec.exp    = a[SP_W-2:SP_FRAC_W];
        dec.frac   = a[SP_FRAC_W-1:0];
        dec.cls    = classify(a[SP_W-2:SP_FRAC_W], a[SP_FRAC_W-1:0]);
        dec.lz     = lz;
    end
endmodule

// File: rtl/fpws_widen.sv
module fpws_widen
    import fpws_pkg::*;
(
    input  stage1_t         s,
    output logic [DP_W-1:0] result,
    output flags_t          flags
);
    logic [SP_FRAC_W-1:0] shifted;
    logic [SP_FRAC_W-1:0] norm_frac;
    logic [DP_EXP_W-1:0]  exp_d;
    logic [DP_FRAC_W-1:0] frac_d;

    always_comb begin
        shifted   = s.frac << s.lz;
        norm_frac = {shifted[SP_FRAC_W-2:0], 1'b0};
        flags     = '0;
        exp_d     = '0;
        frac_d    = '0;
        unique case (s.cls)
            CLS_ZERO: begin
                exp_d  = '0;
                frac_d = '0;
            end
            CLS_SUB: begin
                exp_d  = DP_EXP_W'(REBIAS) - DP_EXP_W'(s.lz);
                frac_d = {norm_frac, {PAD_W{1'b0}}};
            end
            CLS_NORM: begin
                exp_d  = DP_EXP_W'(s.exp) + DP_EXP_W'(REBIAS);
                frac_d = {s.frac, {PAD_W{1'b0}}};
            end
            CLS_INF: begin
                exp_d  = '1;
                frac_d = '0;
            end
            CLS_QNAN, CLS_SNAN: begin
                exp_d  = '1;
                frac_d = {1'b1, s.frac[SP_FRAC_W-2:0], {PAD_W{1'b0}}};
                flags.invalid = (s.cls == CLS_SNAN);
            end
            default: begin
                exp_d  = '0;
                frac_d = '0;
            end
        endcase
        result = {s.sign, exp_d, frac_d};
    end
endmodule

// File: rtl/fpws_signop.sv
module fpws_signop
    import fpws_pkg::*;
(
    input  stage1_t         s,
    output logic [DP_W-1:0] result
);
    logic new_sign;

    always_comb begin
        unique case (s.op)
            OP_ABS:   new_sign = 1'b0;
            OP_NEG:   new_sign = ~s.sign;
            OP_CPSGN: new_sign = s.sign_b;
            default:  new_sign = s.sign;
        endcase
        result = {{(DP_W - SP_W){1'b0}}, new_sign, s.exp, s.frac};
    end
endmodule

// File: rtl/fp_widen_sign_unit.sv
module fp_widen_sign_unit
    import fpws_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_op,
    input  logic [SP_W-1:0]   in_a,
    input  logic [SP_W-1:0]   in_b,
    output logic              out_valid,
    output logic [DP_W-1:0]   out_result,
    output logic [FLAG_W-1:0] out_flags
);
    stage1_t         dec;
    stage1_t         s1_q;
    logic            s1_v_q;
    logic [DP_W-1:0] widen_res;
    flags_t          widen_flg;
    logic [DP_W-1:0] sign_res;
    stage2_t         s2_d;
    stage2_t         s2_q;
    logic            s2_v_q;

    assign in_ready = ~rst;

    fpws_decode u_decode (
        .op  (in_op),
        .a   (in_a),
        .b   (in_b),
        .dec (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v_q <= 1'b0;
            s1_q   <= '0;
        end else begin
            s1_v_q <= in_valid && in_ready;
            if (in_valid && in_ready)
                s1_q <= dec;
        end
    end

    fpws_widen u_widen (
        .s      (s1_q),
        .result (widen_res),
        .flags  (widen_flg)
    );

    fpws_signop u_signop (
        .s      (s1_q),
        .result (sign_res)
    );

    always_comb begin
        if (s1_q.op == OP_WIDEN) begin
            s2_d.result = widen_res;
            s2_d.flags  = widen_flg;
        end else begin
            s2_d.result = sign_res;
            s2_d.flags  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_v_q <= 1'b0;
            s2_q   <= '0;
        end else begin
            s2_v_q <= s1_v_q;
            if (s1_v_q)
                s2_q <= s2_d;
        end
    end

    assign out_valid  = s2_v_q;
    assign out_result = s2_q.result;
    assign out_flags  = s2_q.flags;
endmodule

// File: rtl/fpws_checker.sv
module fpws_checker
    import fpws_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [1:0]        in_op,
    input logic [SP_W-1:0]   in_a,
    input logic [SP_W-1:0]   in_b,
    input logic              out_valid,
    input logic [DP_W-1:0]   out_result,
    input logic [FLAG_W-1:0] out_flags
);
    logic accepted;
    assign accepted = in_valid && in_ready;

    assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(accepted, 2));

    assert_quiet_signops_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(in_op, 2) != 2'd0) |-> out_flags == '0);

    assert_snan_quieted_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_flags[4]) |->
        (out_result[62:52] == 11'h7ff && out_result[51] && !$past(in_a[22], 2)));

    assert_zero_sign_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(in_op, 2) == 2'd0 && $past(in_a[30:0], 2) == 31'd0) |->
        (out_result[62:0] == 63'd0 && out_result[63] == $past(in_a[31], 2)));

    assert_spare_flags_R11: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_flags[3:0] == 4'd0);

    always @(posedge clk) begin
        if (!rst) begin
            assert_ready_R10: assert (in_ready);
        end
    end
endmodule

bind fp_widen_sign_unit fpws_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_op      (in_op),
    .in_a       (in_a),
    .in_b       (in_b),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_flags  (out_flags)
);

// File: tb/fp_widen_sign_unit_tb.sv
module fp_widen_sign_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_op = 2'd0;
    logic [31:0] in_a = 32'd0;
    logic [31:0] in_b = 32'd0;
    logic        out_valid;
    logic [63:0] out_result;
    logic [4:0]  out_flags;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic        h_v   [2];
    logic [63:0] h_res [2];
    logic [4:0]  h_flg [2];
    string       h_req [2];

    always #(CLK_PERIOD / 2) clk = ~clk;

    fp_widen_sign_unit u_dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_op      (in_op),
        .in_a       (in_a),
        .in_b       (in_b),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_flags  (out_flags)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_widen(input logic [31:0] a, output bit inv);
        logic        s;
        logic [7:0]  e;
        logic [22:0] f;
        logic [22:0] m;
        int          k;
        s = a[31]; e = a[30:23]; f = a[22:0];
        inv = 1'b0;
        if (e == 8'hff) begin
            if (f == 0) return {s, 11'h7ff, 52'd0};
            inv = !f[22];
            return {s, 11'h7ff, 1'b1, f[21:0], 29'd0};
        end
        if (e == 8'h00) begin
            if (f == 0) return {s, 63'd0};
            m = f; k = 0;
            while (!m[22]) begin
                m = m << 1;
                k++;
            end
            return {s, 11'(896 - k), m[21:0], 30'd0};
        end
        return {s, 11'(int'(e) + 896), f, 29'd0};
    endfunction

    function automatic string req_of(input logic [1:0] op, input logic [31:0] a);
        if (op == 2'd1) return "R6";
        if (op == 2'd2) return "R7";
        if (op == 2'd3) return "R8";
        if (a[30:23] == 8'hff && a[22:0] != 0) return a[22] ? "R5" : "R4";
        if (a[30:23] == 8'hff || a[30:0] == 0) return "R3";
        if (a[30:23] == 8'h00) return "R2";
        return "R1";
    endfunction

    task automatic step(input bit v, input logic [1:0] op,
                        input logic [31:0] a, input logic [31:0] b);
        bit          inv;
        logic [63:0] r;
        @(negedge clk);
        check(out_valid === h_v[1], "R9", "out_valid timing",
              64'(out_valid), 64'(h_v[1]));
        if (h_v[1]) begin
            check(out_result === h_res[1], h_req[1], "result", out_result, h_res[1]);
            check(out_flags === h_flg[1], {h_req[1], " R11"}, "flags",
                  64'(out_flags), 64'(h_flg[1]));
        end
        h_v[1] = h_v[0]; h_res[1] = h_res[0]; h_flg[1] = h_flg[0]; h_req[1] = h_req[0];
        inv = 1'b0;
        case (op)
            2'd0: r = ref_widen(a, inv);
            2'd1: r = {32'd0, 1'b0, a[30:0]};
            2'd2: r = {32'd0, ~a[31], a[30:0]};
            default: r = {32'd0, b[31], a[30:0]};
        endcase
        h_v[0] = v; h_res[0] = r; h_flg[0] = {inv, 4'd0}; h_req[0] = req_of(op, a);
        in_valid = v; in_op = op; in_a = a; in_b = b;
    endtask

    function automatic logic [31:0] rand_operand();
        logic [31:0] x;
        x = $urandom;
        case ($urandom % 6)
            0: x[30:23] = 8'h00;
            1: x[30:23] = 8'hff;
            2: x[30:0]  = 31'd0;
            3: x[30:0]  = {8'hff, 23'd0};
            default: ;
        endcase
        return x;
    endfunction

    initial begin
        h_v[0] = 1'b0; h_v[1] = 1'b0;
        h_res[0] = '0; h_res[1] = '0;
        h_flg[0] = '0; h_flg[1] = '0;
        h_req[0] = "R9"; h_req[1] = "R9";
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10: reset state
        check(in_ready === 1'b0, "R10", "in_ready in reset", 64'(in_ready), 64'd0);
        check(out_valid === 1'b0, "R10", "out_valid in reset", 64'(out_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready === 1'b1, "R10", "in_ready after reset", 64'(in_ready), 64'd1);

        // R1 normal widening
        step(1, 2'd0, 32'h3f800000, 32'd0);
        step(1, 2'd0, 32'hc0490fdb, 32'd0);
        step(1, 2'd0, 32'h7f7fffff, 32'd0);
        step(1, 2'd0, 32'h00800000, 32'd0);
        // R2 subnormals: largest, smallest, top-bit
        step(1, 2'd0, 32'h007fffff, 32'd0);
        step(1, 2'd0, 32'h80000001, 32'd0);
        step(1, 2'd0, 32'h00400000, 32'd0);
        // R3 zeros and infinities
        step(1, 2'd0, 32'h00000000, 32'd0);
        step(1, 2'd0, 32'h80000000, 32'd0);
        step(1, 2'd0, 32'h7f800000, 32'd0);
        step(1, 2'd0, 32'hff800000, 32'd0);
        // R4 signaling NaN widening (0x7fa00000 -> 0x7ffc000000000000)
        step(1, 2'd0, 32'h7fa00000, 32'd0);
        step(1, 2'd0, 32'hffb00000, 32'd0);
        step(1, 2'd0, 32'h7f800001, 32'd0);
        // R5 quiet NaN widening
        step(1, 2'd0, 32'hffc00000, 32'd0);
        step(1, 2'd0, 32'h7fc12345, 32'd0);
        // R6 R7 R8 sign ops on signaling NaN and ordinary values
        step(1, 2'd1, 32'hffb00000, 32'd0);
        step(1, 2'd2, 32'h7fa00000, 32'd0);
        step(1, 2'd3, 32'h7fa00000, 32'h80000000);
        step(1, 2'd1, 32'hc0000000, 32'd0);
        step(1, 2'd2, 32'h00000000, 32'd0);
        step(1, 2'd3, 32'hbf800000, 32'h3f000000);
        // R9 idle gap then drain
        step(0, 2'd0, 32'h3f800000, 32'd0);
        step(0, 2'd0, 32'd0, 32'd0);

        // random traffic with gaps
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 4) != 0, 2'($urandom % 4), rand_operand(), $urandom);
        end
        step(0, 2'd0, 32'd0, 32'd0);
        step(0, 2'd0, 32'd0, 32'd0);
        step(0, 2'd0, 32'd0, 32'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule